// File: doc/BRIEF.md
# Debug Monitor Entry Controller

This block decides whether a small microcontroller core comes up in a debug monitor mode or in normal user mode. The mode is settled when the external reset pin is released. If a high-voltage detect flag is present at that moment, the core enters monitor mode. A software-interrupt event seen while the high voltage is present also enters monitor mode. The level of a clock-select pin at the same release decides whether the oscillator's divide-by-two stage is bypassed.

In monitor mode, vector fetches are steered to an alternate page, so the core runs monitor firmware instead of user code. The watchdog enable is held off for as long as the high voltage stays applied. Each time the block enters monitor mode, it sends a break character on its serial output: ten low bit times, paced by an external bit-time tick. A host uses the break to find the baud timing.

The asynchronous pins (reset pin, high-voltage detect, clock select) pass through two-stage synchronizers. The mode decision is taken on the cycle after the synchronized reset pin rises.

Top module: `mon_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are: `mon_mode_o`=0, `clk_bypass_o`=0, `tx_o`=1, `brk_done_o`=0, `wdog_en_o` equal to `cfg_wdog_en_i`, and `addr_o` equal to `vec_addr_i`.
- R2: A low-to-high transition of `rst_pin_i` selects the mode. Monitor mode (`mon_mode_o`=1) is chosen if `hv_det_i` is high, and user mode (`mon_mode_o`=0) if it is low. Each of these inputs passes through two synchronizer flops before it is used.
- R3: A one-cycle `swi_i` pulse while the synchronized high-voltage flag is high sets `mon_mode_o` on the next clock. A pulse while the flag is low changes neither `mon_mode_o` nor `tx_o`.
- R4: Each monitor entry arms the break transmitter. `tx_o` goes low at the first `bit_tick_i` after entry and stays low until the tenth tick after that one, at which point it returns high. `brk_done_o` is high for exactly the one cycle that follows that tenth tick.
- R5: When `mon_mode_o`=1 and `vec_fetch_i`=1, an address whose upper byte is 0xFF is output with an upper byte of 0xFE and the same lower byte. So 0xFFFE/0xFFFF become 0xFEFE/0xFEFF, and 0xFFFC/0xFFFD become 0xFEFC/0xFEFD.
- R6: Every other address is output unchanged. This covers user mode, cycles that are not vector fetches, and upper bytes other than 0xFF.
- R7: In monitor mode, `wdog_en_o` is 0 while the synchronized high-voltage flag is high, and 1 once the flag drops. In user mode, `wdog_en_o` follows `cfg_wdog_en_i`.
- R8: At a reset-pin release that enters monitor mode, `clk_bypass_o` is set when the synchronized clock-select is low and cleared when it is high. A release into user mode clears it. The value is held until the next release: later changes of `clk_sel_i` and entries by software interrupt leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| rst_pin_i | input | 1 | External reset pin level (asynchronous) |
| hv_det_i | input | 1 | High-voltage detect flag (asynchronous) |
| clk_sel_i | input | 1 | Clock-select pin; low requests the divider bypass (asynchronous) |
| swi_i | input | 1 | Software-interrupt event pulse |
| cfg_wdog_en_i | input | 1 | Watchdog enable from configuration, used in user mode |
| vec_fetch_i | input | 1 | Marks the current address as a vector fetch |
| vec_addr_i | input | 16 | Fetch address from the core |
| bit_tick_i | input | 1 | One-cycle pulse per serial bit time |
| addr_o | output | 16 | Address after remapping |
| wdog_en_o | output | 1 | Watchdog enable |
| clk_bypass_o | output | 1 | Bypass the divide-by-two stage |
| tx_o | output | 1 | Serial line, idle high |
| brk_done_o | output | 1 | One-cycle pulse when the break ends |
| mon_mode_o | output | 1 | Monitor mode active |

## Verification
Some properties are checked by assertions on every cycle:
- the divider bypass is never set outside monitor mode, and changes only at a reset-pin release;
- a qualified software interrupt always lands in monitor mode;
- the break counter stays within range, and the line holds low between ticks;
- every vector fetch in monitor mode is remapped;
- the watchdog stays off while the high voltage is applied in monitor mode.

Other properties only the bench scenarios can show:
- the exact count of ten low bit times and the placement of the done pulse;
- that clock-select changes and software-interrupt entries leave the latched bypass alone;
- that an unqualified software interrupt is ignored;
- the passthrough over a broad sweep of addresses in both modes.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [1:0] {
    BRK_IDLE  = 2'd0,
    BRK_ARMED = 2'd1,
    BRK_SEND  = 2'd2
  } brk_state_e;

  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int i = 1; i < int'(STAGES); i++) stg_d[i] = stg_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < int'(STAGES); g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mon_mode_ctrl.sv
module mon_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic hv_s_i,
  input  logic clksel_s_i,
  input  logic swi_i,
  output logic mon_o,
  output logic bypass_o,
  output logic start_o
);

  logic pin_d_q;
  logic mon_q, mon_d;
  logic bypass_q, bypass_d;
  logic release_w;
  logic swi_entry_w;

  assign release_w   = pin_s_i & ~pin_d_q;
  assign swi_entry_w = swi_i & hv_s_i;

  always_comb begin
    mon_d    = mon_q;
    bypass_d = bypass_q;
    if (release_w) begin
      mon_d    = hv_s_i;
      bypass_d = hv_s_i & ~clksel_s_i;
    end else if (swi_entry_w) begin
      mon_d    = 1'b1;
    end
  end

  assign start_o = hv_s_i & (release_w | swi_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_d_q  <= 1'b0;
      mon_q    <= 1'b0;
      bypass_q <= 1'b0;
    end else begin
      pin_d_q  <= pin_s_i;
      mon_q    <= mon_d;
      bypass_q <= bypass_d;
    end
  end

  assign mon_o    = mon_q;
  assign bypass_o = bypass_q;

  a_r8_bypass_only_in_mon : assert property (@(posedge clk) disable iff (!rst_n)
    bypass_q |-> mon_q);

  a_r8_bypass_held : assert property (@(posedge clk) disable iff (!rst_n)
    !release_w |=> $stable(bypass_q));

  a_r3_swi_enters : assert property (@(posedge clk) disable iff (!rst_n)
    (swi_i && hv_s_i) |=> mon_q);

endmodule

// File: rtl/mon_break_tx.sv
module mon_break_tx
  import mon_entry_pkg::*;
#(
  parameter int unsigned BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  output logic tx_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  brk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = BRK_ARMED;
      cnt_d   = '0;
    end else begin
      case (state_q)
        BRK_ARMED: if (tick_i) begin
          state_d = BRK_SEND;
          cnt_d   = '0;
        end
        BRK_SEND: if (tick_i) begin
          if (cnt_q == LAST) begin
            state_d = BRK_IDLE;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BRK_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign tx_o   = (state_q != BRK_SEND);
  assign done_o = done_q;

  a_r4_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BRK_SEND) |-> (cnt_q <= LAST));

  a_r4_low_between_ticks : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BRK_SEND && !tick_i && !start_i) |=> !tx_o);

  a_r4_done_after_send : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tx_o && $past(state_q) == BRK_SEND));

endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 8,
  parameter logic [PAGE_W-1:0] VEC_PAGE = 8'hFF,
  parameter logic [PAGE_W-1:0] ALT_PAGE = 8'hFE
) (
  input  logic              mon_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned LOW_W = ADDR_W - PAGE_W;

  logic hit_w;

  assign hit_w  = mon_i & fetch_i & (addr_i[ADDR_W-1:LOW_W] == VEC_PAGE);
  assign addr_o = hit_w ? {ALT_PAGE, addr_i[LOW_W-1:0]} : addr_i;

endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] VEC_PAGE = 8'hFF,
  parameter logic [PAGE_W-1:0] ALT_PAGE = 8'hFE,
  parameter int unsigned BRK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_pin_i,
  input  logic              hv_det_i,
  input  logic              clk_sel_i,
  input  logic              swi_i,
  input  logic              cfg_wdog_en_i,
  input  logic              vec_fetch_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  input  logic              bit_tick_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wdog_en_o,
  output logic              clk_bypass_o,
  output logic              tx_o,
  output logic              brk_done_o,
  output logic              mon_mode_o
);

  localparam int unsigned LOW_W = ADDR_W - PAGE_W;

  logic [2:0] pins_raw, pins_s;
  logic       pin_s, hv_s, clksel_s;
  logic       mon_w, start_w;

  assign pins_raw = {rst_pin_i, hv_det_i, clk_sel_i};

  mon_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b000)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  assign pin_s    = pins_s[2];
  assign hv_s     = pins_s[1];
  assign clksel_s = pins_s[0];

  mon_mode_ctrl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_s_i   (pin_s),
    .hv_s_i    (hv_s),
    .clksel_s_i(clksel_s),
    .swi_i     (swi_i),
    .mon_o     (mon_w),
    .bypass_o  (clk_bypass_o),
    .start_o   (start_w)
  );

  mon_break_tx #(.BITS(BRK_BITS)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_w),
    .tick_i (bit_tick_i),
    .tx_o   (tx_o),
    .done_o (brk_done_o)
  );

  mon_vec_remap #(
    .ADDR_W  (ADDR_W),
    .PAGE_W  (PAGE_W),
    .VEC_PAGE(VEC_PAGE),
    .ALT_PAGE(ALT_PAGE)
  ) u_remap (
    .mon_i  (mon_w),
    .fetch_i(vec_fetch_i),
    .addr_i (vec_addr_i),
    .addr_o (addr_o)
  );

  assign wdog_en_o  = mon_w ? ~hv_s : cfg_wdog_en_i;
  assign mon_mode_o = mon_w;

  a_r5_vector_page_moved : assert property (@(posedge clk) disable iff (!rst_n)
    (mon_mode_o && vec_fetch_i && vec_addr_i[ADDR_W-1:LOW_W] == VEC_PAGE) |->
      (addr_o[ADDR_W-1:LOW_W] == ALT_PAGE && addr_o[LOW_W-1:0] == vec_addr_i[LOW_W-1:0]));

  a_r7_wdog_off_under_hv : assert property (@(posedge clk) disable iff (!rst_n)
    (mon_mode_o && hv_s && $past(hv_s)) |-> !wdog_en_o);

endmodule

// File: tb/sim_mon_entry_ctrl.sv
module sim_mon_entry_ctrl;

  localparam time CLK_PER = 10ns;
  localparam int  BITS    = 10;

  logic        clk = 1'b0;
  logic        rst_n, rst_pin, hv, csel, swi, cfg, fetch, tick;
  logic [15:0] addr, addr_o;
  logic        wdog, byp, tx, done, mon;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mon_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin), .hv_det_i(hv),
    .clk_sel_i(csel), .swi_i(swi), .cfg_wdog_en_i(cfg),
    .vec_fetch_i(fetch), .vec_addr_i(addr), .bit_tick_i(tick),
    .addr_o(addr_o), .wdog_en_o(wdog), .clk_bypass_o(byp), .tx_o(tx),
    .brk_done_o(done), .mon_mode_o(mon)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pin_cycle();
    @(negedge clk) rst_pin = 1'b0;
    cyc(4);
    rst_pin = 1'b1;
    cyc(5);
  endtask

  // R4: ten low bit times, then idle with one done pulse
  task automatic run_break(input string tag);
    chk(tx, 1'b1, {tag, " R4 armed idle"});
    pulse_tick();
    chk(tx, 1'b0, {tag, " R4 first tick low"});
    for (int k = 2; k <= BITS + 1; k++) begin
      cyc(3);
      chk(tx, 1'b0, {tag, " R4 low between ticks"});
      pulse_tick();
      if (k == BITS + 1) begin
        chk(tx, 1'b1, {tag, " R4 line idle after break"});
        chk(done, 1'b1, {tag, " R4 done pulse"});
      end else begin
        chk(tx, 1'b0, {tag, " R4 still low"});
        chk(done, 1'b0, {tag, " R4 no early done"});
      end
    end
    cyc(1);
    chk(done, 1'b0, {tag, " R4 done one cycle"});
    pulse_tick();
    chk(tx, 1'b1, {tag, " R4 no second break"});
  endtask

  // R5/R6: address sweep with expected value computed here
  task automatic sweep(input logic in_mon, input string tag);
    for (int i = 0; i < 65536; i += 11) begin
      @(negedge clk);
      addr  = 16'(i);
      fetch = 1'(i[0] ^ i[9]);
      #1;
      chk(addr_o, (in_mon && fetch && addr[15:8] == 8'hFF) ? {8'hFE, addr[7:0]} : addr,
          {tag, " R5 R6 sweep"});
    end
    for (int j = 0; j < 256; j++) begin
      @(negedge clk);
      addr  = {8'hFF, 8'(j)};
      fetch = 1'b1;
      #1;
      chk(addr_o, in_mon ? {8'hFE, 8'(j)} : {8'hFF, 8'(j)}, {tag, " R5 R6 top page"});
    end
    fetch = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rst_pin = 1'b0; hv = 1'b0; csel = 1'b1; swi = 1'b0;
    cfg = 1'b1; fetch = 1'b1; tick = 1'b0; addr = 16'hFFFE;
    cyc(3);
    // R1
    chk(mon, 1'b0, "R1 mon");
    chk(byp, 1'b0, "R1 bypass");
    chk(tx, 1'b1, "R1 tx");
    chk(done, 1'b0, "R1 done");
    chk(wdog, 1'b1, "R1 wdog");
    chk(addr_o, 16'hFFFE, "R1 addr");
    rst_n = 1'b1;
    cyc(2);

    // R2 user mode
    rst_pin = 1'b1;
    cyc(5);
    chk(mon, 1'b0, "R2 user release");
    chk(tx, 1'b1, "R2 no break in user");
    cfg = 1'b0; #1;
    chk(wdog, 1'b0, "R7 user cfg low");
    cfg = 1'b1; #1;
    chk(wdog, 1'b1, "R7 user cfg high");
    sweep(1'b0, "user");

    // R3 unqualified SWI ignored
    @(negedge clk) swi = 1'b1;
    @(negedge clk) swi = 1'b0;
    cyc(2);
    chk(mon, 1'b0, "R3 swi without hv");
    chk(tx, 1'b1, "R3 swi without hv tx");
    pulse_tick();
    chk(tx, 1'b1, "R3 swi without hv no break");

    // R2 R8 monitor entry with bypass
    hv = 1'b1; csel = 1'b0;
    cyc(4);
    pin_cycle();
    chk(mon, 1'b1, "R2 monitor entry");
    chk(byp, 1'b1, "R8 bypass when clksel low");
    chk(wdog, 1'b0, "R7 wdog off under hv");
    run_break("pin entry");
    sweep(1'b1, "mon");
    addr = 16'hFFFE; fetch = 1'b1; #1;
    chk(addr_o, 16'hFEFE, "R5 reset hi");
    addr = 16'hFFFF; #1;
    chk(addr_o, 16'hFEFF, "R5 reset lo");
    addr = 16'hFFFC; #1;
    chk(addr_o, 16'hFEFC, "R5 swi hi");
    addr = 16'hFFFD; #1;
    chk(addr_o, 16'hFEFD, "R5 swi lo");
    fetch = 1'b0; #1;
    chk(addr_o, 16'hFFFD, "R6 non-fetch passthrough");

    // R8 clksel change ignored
    csel = 1'b1;
    cyc(5);
    chk(byp, 1'b1, "R8 bypass held");

    // R7 hv removed
    cfg = 1'b0;
    hv = 1'b0;
    cyc(4);
    chk(mon, 1'b1, "R7 still monitor");
    chk(wdog, 1'b1, "R7 wdog on after hv drop");
    hv = 1'b1;
    cyc(4);
    chk(wdog, 1'b0, "R7 wdog off again");
    cfg = 1'b1;

    // R8 release with clksel high
    pin_cycle();
    chk(mon, 1'b1, "R2 re-entry");
    chk(byp, 1'b0, "R8 no bypass when clksel high");
    run_break("re-entry");

    // R2 leave to user mode
    hv = 1'b0;
    cyc(4);
    pin_cycle();
    chk(mon, 1'b0, "R2 back to user");
    chk(byp, 1'b0, "R8 user clears bypass");

    // R3 SWI entry, R8 bypass untouched
    hv = 1'b1; csel = 1'b0;
    cyc(4);
    @(negedge clk) swi = 1'b1;
    @(negedge clk) swi = 1'b0;
    chk(mon, 1'b1, "R3 swi enters monitor");
    chk(byp, 1'b0, "R8 swi leaves bypass");
    run_break("swi entry");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule